// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with Hi/Lo Result Registers

This block is the integer multiply and divide engine of a 32-bit processor. It has its own pair of result registers, called hi and lo, and it never writes the general register file. A multiply leaves the full double-width product split across the two registers. A divide leaves the quotient in lo and the remainder in hi. Each multiply and divide comes in a signed form and an unsigned form. Two further commands load hi or lo directly from an operand. A separate read port returns either register.

The arithmetic is iterative. A multiply uses one shift-and-add step per operand bit. A divide uses one restoring step per bit. Both run on operand magnitudes, and the signs are applied in a final correction cycle. While an operation is running, the unit raises `busy`, which the pipeline uses to hold off a read of hi or lo. A divide by zero does no work: it completes at once and raises a status flag. A direct write to hi or lo during a running operation cancels that operation.

Top module: `mdu_core`

## Requirements
- R1: Command code 1 (signed multiply) treats `opa` and `opb` as two's-complement values. After completion, lo holds bits 31..0 and hi holds bits 63..32 of the 64-bit product.
- R2: Command code 2 (unsigned multiply) treats both operands as unsigned. It fills lo and hi the same way as R1.
- R3: Command code 3 (signed divide) writes the quotient, truncated toward zero, to lo. It writes to hi the remainder, which carries the sign of the dividend. The case 0x80000000 / -1 gives lo = 0x80000000 and hi = 0.
- R4: Command code 4 (unsigned divide) writes the unsigned quotient to lo and the unsigned remainder to hi.
- R5: An accepted multiply, or a divide with a nonzero divisor, raises `busy` on the cycle after acceptance. `busy` stays high for exactly 33 cycles. It falls on the same clock edge that writes hi and lo.
- R6: `rd_valid` equals `rd_req` while `busy` is low and is 0 while `busy` is high. `rd_data` returns hi when `rd_sel` is 1 and lo when `rd_sel` is 0.
- R7: A multiply or divide command presented while `busy` is high is ignored. The running operation completes with its own result.
- R8: An accepted divide whose `opb` is zero sets `dz_flag` to 1 on the next cycle. `busy` does not rise, and hi and lo keep their values. Any later accepted multiply or divide with a nonzero divisor clears `dz_flag`.
- R9: Command code 5 loads `opa` into hi, and command code 6 loads `opa` into lo. Each takes effect on the next clock edge and leaves the other register unchanged. Codes 0 and 7 do nothing.
- R10: Code 5 or 6 presented while `busy` is high cancels the running operation. `busy` is low on the next cycle, and the named register takes `opa`. The other register keeps the value it had before the cancelled operation, and no result is written later.
- R11: Synchronous active-high `rst` clears hi, lo, `busy` and `dz_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code (1 mul signed, 2 mul unsigned, 3 div signed, 4 div unsigned, 5 load hi, 6 load lo) |
| opa | input | 32 | First operand or dividend; data for hi/lo loads |
| opb | input | 32 | Second operand or divisor |
| rd_req | input | 1 | Request to read hi or lo |
| rd_sel | input | 1 | Read select: 1 hi, 0 lo |
| rd_valid | output | 1 | Read data is usable this cycle |
| rd_data | output | 32 | Selected result register |
| busy | output | 1 | Operation in progress |
| dz_flag | output | 1 | Last accepted multiply/divide was a divide by zero |

## Verification
Two conditions are hard to reach from the ports. The first is a direct hi/lo write that arrives in the middle of an iteration. The second is a new arithmetic command that arrives while the unit is busy. Both must be aligned to a particular cycle inside the 33-cycle window. The bench drives these commands on falling edges at known offsets after acceptance. It then checks that the cancelled result never appears, even long after the window would have closed. The signed extremes are exercised as well, including the most negative dividend over -1 and the product of two most negative values.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_MULS  = 3'd1,
        OP_MULU  = 3'd2,
        OP_DIVS  = 3'd3,
        OP_DIVU  = 3'd4,
        OP_SETHI = 3'd5,
        OP_SETLO = 3'd6,
        OP_RSVD  = 3'd7
    } mdu_op_e;

    typedef struct packed {
        logic mul;
        logic div;
        logic sgn;
        logic set_hi;
        logic set_lo;
    } mdu_dec_t;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_RUN  = 2'd1,
        SQ_FIX  = 2'd2
    } mdu_seq_e;

    typedef struct packed {
        logic is_div;
        logic neg_main;
        logic neg_rem;
    } mdu_fix_t;

    function automatic mdu_dec_t mdu_decode(input logic [2:0] op);
        mdu_dec_t d;
        d = '0;
        case (mdu_op_e'(op))
            OP_MULS:  begin d.mul = 1'b1; d.sgn = 1'b1; end
            OP_MULU:  d.mul = 1'b1;
            OP_DIVS:  begin d.div = 1'b1; d.sgn = 1'b1; end
            OP_DIVU:  d.div = 1'b1;
            OP_SETHI: d.set_hi = 1'b1;
            OP_SETLO: d.set_lo = 1'b1;
            default:  d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/mdu_seq.sv
module mdu_seq
    import mdu_pkg::*;
#(
    parameter int ITER = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic abort,
    output logic step,
    output logic fin,
    output logic busy
);
    localparam int CW = (ITER > 1) ? $clog2(ITER) : 1;
    localparam logic [CW-1:0] LAST = CW'(ITER - 1);

    mdu_seq_e        state;
    logic [CW-1:0]   cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (start) begin
                        state <= SQ_RUN;
                        cnt   <= '0;
                    end
                end
                SQ_RUN: begin
                    if (abort) begin
                        state <= SQ_IDLE;
                    end else if (cnt == LAST) begin
                        state <= SQ_FIX;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SQ_FIX:  state <= SQ_IDLE;
                default: state <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        step = (state == SQ_RUN) && !abort;
        fin  = (state == SQ_FIX) && !abort;
        busy = (state != SQ_IDLE);
    end

endmodule

// File: rtl/mdu_mul_eng.sv
module mdu_mul_eng #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           load,
    input  logic           step,
    input  logic [W-1:0]   a_mag,
    input  logic [W-1:0]   b_mag,
    output logic [2*W-1:0] prod
);
    logic [2*W-1:0] acc;
    logic [W-1:0]   mcand;
    logic [W:0]     psum;

    always_comb begin
        psum = {1'b0, acc[2*W-1:W]} + (acc[0] ? {1'b0, mcand} : '0);
    end

    always_ff @(posedge clk) begin
        if (load) begin
            acc   <= {{W{1'b0}}, a_mag};
            mcand <= b_mag;
        end else if (step) begin
            acc <= {psum, acc[W-1:1]};
        end
    end

    assign prod = acc;

endmodule

// File: rtl/mdu_div_eng.sv
module mdu_div_eng #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] dvd_mag,
    input  logic [W-1:0] dvs_mag,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    logic [W:0]   part;
    logic [W-1:0] quo_q;
    logic [W-1:0] dvs_q;
    logic [W:0]   shifted;
    logic [W:0]   trial;

    always_comb begin
        shifted = {part[W-1:0], quo_q[W-1]};
        trial   = shifted - {1'b0, dvs_q};
    end

    always_ff @(posedge clk) begin
        if (load) begin
            part  <= '0;
            quo_q <= dvd_mag;
            dvs_q <= dvs_mag;
        end else if (step) begin
            if (trial[W]) begin
                part  <= shifted;
                quo_q <= {quo_q[W-2:0], 1'b0};
            end else begin
                part  <= trial;
                quo_q <= {quo_q[W-2:0], 1'b1};
            end
        end
    end

    assign quo = quo_q;
    assign rem = part[W-1:0];

endmodule

// File: rtl/mdu_core.sv
module mdu_core
    import mdu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cmd_valid,
    input  logic [2:0]   cmd_op,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         rd_req,
    input  logic         rd_sel,
    output logic         rd_valid,
    output logic [W-1:0] rd_data,
    output logic         busy,
    output logic         dz_flag
);
    localparam int ITER = W;

    function automatic logic [W-1:0] neg_w(input logic [W-1:0] x);
        return (~x) + 1'b1;
    endfunction

    function automatic logic [2*W-1:0] neg_2w(input logic [2*W-1:0] x);
        return (~x) + 1'b1;
    endfunction

    mdu_dec_t       dec;
    logic           arith_acc;
    logic           div_zero;
    logic           start;
    logic           direct;
    logic           abort;
    logic           sa;
    logic           sb;
    logic [W-1:0]   a_mag;
    logic [W-1:0]   b_mag;
    logic           step;
    logic           fin;
    logic [2*W-1:0] prod;
    logic [W-1:0]   quo;
    logic [W-1:0]   rem;
    logic [2*W-1:0] prod_fix;
    logic [W-1:0]   quo_fix;
    logic [W-1:0]   rem_fix;
    mdu_fix_t       fix_q;
    logic [W-1:0]   hi_q;
    logic [W-1:0]   lo_q;

    always_comb begin
        dec       = mdu_decode(cmd_op);
        arith_acc = cmd_valid && !busy && (dec.mul || dec.div);
        div_zero  = dec.div && (opb == '0);
        start     = arith_acc && !div_zero;
        direct    = cmd_valid && (dec.set_hi || dec.set_lo);
        abort     = direct && busy;
        sa        = dec.sgn && opa[W-1];
        sb        = dec.sgn && opb[W-1];
        a_mag     = sa ? neg_w(opa) : opa;
        b_mag     = sb ? neg_w(opb) : opb;
    end

    mdu_seq #(.ITER(ITER)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .abort (abort),
        .step  (step),
        .fin   (fin),
        .busy  (busy)
    );

    mdu_mul_eng #(.W(W)) u_mul (
        .clk   (clk),
        .load  (start),
        .step  (step),
        .a_mag (a_mag),
        .b_mag (b_mag),
        .prod  (prod)
    );

    mdu_div_eng #(.W(W)) u_div (
        .clk     (clk),
        .load    (start),
        .step    (step),
        .dvd_mag (a_mag),
        .dvs_mag (b_mag),
        .quo     (quo),
        .rem     (rem)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fix_q <= '0;
        end else if (start) begin
            fix_q.is_div   <= dec.div;
            fix_q.neg_main <= sa ^ sb;
            fix_q.neg_rem  <= sa;
        end
    end

    always_comb begin
        prod_fix = fix_q.neg_main ? neg_2w(prod) : prod;
        quo_fix  = fix_q.neg_main ? neg_w(quo) : quo;
        rem_fix  = fix_q.neg_rem  ? neg_w(rem) : rem;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q    <= '0;
            lo_q    <= '0;
            dz_flag <= 1'b0;
        end else begin
            if (arith_acc) begin
                dz_flag <= div_zero;
            end
            if (fin) begin
                if (fix_q.is_div) begin
                    hi_q <= rem_fix;
                    lo_q <= quo_fix;
                end else begin
                    hi_q <= prod_fix[2*W-1:W];
                    lo_q <= prod_fix[W-1:0];
                end
            end
            if (direct && dec.set_hi) begin
                hi_q <= opa;
            end
            if (direct && dec.set_lo) begin
                lo_q <= opa;
            end
        end
    end

    always_comb begin
        rd_valid = rd_req && !busy;
        rd_data  = rd_sel ? hi_q : lo_q;
    end

endmodule

// File: rtl/mdu_core_chk.sv
module mdu_core_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         cmd_valid,
    input logic [2:0]   cmd_op,
    input logic [W-1:0] opa,
    input logic [W-1:0] opb,
    input logic         rd_valid,
    input logic         busy,
    input logic         dz_flag,
    input logic [W-1:0] hi_q,
    input logic [W-1:0] lo_q
);
    localparam int BUSY_MAX = W + 1;
    localparam int BW = $clog2(BUSY_MAX + 2) + 1;

    logic [BW-1:0] bcnt;
    logic          is_arith;
    logic          is_div;
    logic          zero_div;

    always_comb begin
        is_arith = (cmd_op >= 3'd1) && (cmd_op <= 3'd4);
        is_div   = (cmd_op == 3'd3) || (cmd_op == 3'd4);
        zero_div = is_div && (opb == '0);
    end

    always_ff @(posedge clk) begin
        if (rst)       bcnt <= '0;
        else if (busy) bcnt <= bcnt + 1'b1;
        else           bcnt <= '0;
    end

    p_busy_bound_r5: assert property (@(posedge clk) disable iff (rst)
        bcnt <= BW'(BUSY_MAX));

    p_start_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !busy && is_arith && !zero_div) |=> (busy && !dz_flag));

    p_no_read_busy_r6: assert property (@(posedge clk) disable iff (rst)
        busy |-> !rd_valid);

    p_dz_quick_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !busy && zero_div) |=> (!busy && dz_flag));

    p_dz_keep_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !busy && zero_div) |=> ($stable(hi_q) && $stable(lo_q)));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!busy && !cmd_valid) |=> ($stable(hi_q) && $stable(lo_q)));

    p_abort_hi_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_valid && cmd_op == 3'd5) |=> (!busy && hi_q == $past(opa) && $stable(lo_q)));

    p_abort_lo_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_valid && cmd_op == 3'd6) |=> (!busy && lo_q == $past(opa) && $stable(hi_q)));

endmodule

bind mdu_core mdu_core_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .opa       (opa),
    .opb       (opb),
    .rd_valid  (rd_valid),
    .busy      (busy),
    .dz_flag   (dz_flag),
    .hi_q      (hi_q),
    .lo_q      (lo_q)
);

// File: tb/test_mdu_core.sv
`timescale 1ns/1ps
module test_mdu_core;

    typedef struct packed {
        logic [2:0]  op;
        logic [31:0] a;
        logic [31:0] b;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{3'd1, 32'd7,        32'd6},
        '{3'd1, 32'hFFFFFFFD, 32'd5},
        '{3'd1, 32'h80000000, 32'h80000000},
        '{3'd2, 32'hFFFFFFFF, 32'hFFFFFFFF},
        '{3'd2, 32'h12345678, 32'h9ABCDEF0},
        '{3'd3, 32'd100,      32'd7},
        '{3'd3, 32'hFFFFFF9C, 32'd7},
        '{3'd3, 32'd100,      32'hFFFFFFF9},
        '{3'd3, 32'h80000000, 32'hFFFFFFFF},
        '{3'd4, 32'hFFFFFFFF, 32'd16},
        '{3'd4, 32'd5,        32'd16}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        rd_req = 1'b0;
    logic        rd_sel = 1'b0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        busy;
    logic        dz_flag;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    mdu_core i_mdu_core (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .opa       (opa),
        .opb       (opb),
        .rd_req    (rd_req),
        .rd_sel    (rd_sel),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .busy      (busy),
        .dz_flag   (dz_flag)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_hilo(input logic [2:0] op,
                                             input logic [31:0] a,
                                             input logic [31:0] b);
        logic signed [63:0] sa, sb, q, r;
        logic [63:0] p;
        sa = {{32{a[31]}}, a};
        sb = {{32{b[31]}}, b};
        case (op)
            3'd1: p = sa * sb;
            3'd2: p = {32'd0, a} * {32'd0, b};
            3'd3: begin q = sa / sb; r = sa % sb; p = {r[31:0], q[31:0]}; end
            3'd4: p = {a % b, a / b};
            default: p = '0;
        endcase
        return p;
    endfunction

    task automatic issue(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; opa = a; opb = b;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0;
    endtask

    task automatic wait_idle(output int cycles);
        cycles = 0;
        while (busy && cycles < 100) begin
            cycles++;
            @(negedge clk);
        end
    endtask

    task automatic read_reg(input logic sel, output logic [31:0] val, output logic vld);
        rd_req = 1'b1; rd_sel = sel;
        #1;
        val = rd_data; vld = rd_valid;
        rd_req = 1'b0;
    endtask

    task automatic check_hilo(input string req, input logic [31:0] eh, input logic [31:0] el);
        logic [31:0] v; logic ok;
        read_reg(1'b1, v, ok);
        check(req, "hi", v, eh);
        read_reg(1'b0, v, ok);
        check(req, "lo", v, el);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R5 watchdog: actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic        ok;
        logic [63:0] e;
        int          cyc;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state, R6 read select
        check("R11", "busy", {31'd0, busy}, 32'd0);
        check("R11", "dz_flag", {31'd0, dz_flag}, 32'd0);
        read_reg(1'b1, v, ok);
        check("R11", "hi", v, 32'd0);
        check("R6", "rd_valid idle", {31'd0, ok}, 32'd1);
        read_reg(1'b0, v, ok);
        check("R11", "lo", v, 32'd0);

        // R1..R4 table of operations, R5 latency
        for (int i = 0; i < NV; i++) begin
            string req;
            req = (VECS[i].op == 3'd1) ? "R1" : (VECS[i].op == 3'd2) ? "R2" :
                  (VECS[i].op == 3'd3) ? "R3" : "R4";
            issue(VECS[i].op, VECS[i].a, VECS[i].b);
            wait_idle(cyc);
            check("R5", "busy cycles", cyc, 32'd33);
            check("R8", "dz_flag clear", {31'd0, dz_flag}, 32'd0);
            e = ref_hilo(VECS[i].op, VECS[i].a, VECS[i].b);
            check_hilo(req, e[63:32], e[31:0]);
        end

        // R6 read held off while busy; R7 command while busy ignored
        issue(3'd2, 32'd3, 32'd4);
        check("R5", "busy after accept", {31'd0, busy}, 32'd1);
        cmd_valid = 1'b1; cmd_op = 3'd3; opa = 32'd50; opb = 32'd5;
        read_reg(1'b0, v, ok);
        check("R6", "rd_valid busy", {31'd0, ok}, 32'd0);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0;
        wait_idle(cyc);
        check_hilo("R7", 32'd0, 32'd12);

        // R8 divide by zero
        issue(3'd3, 32'd9, 32'd0);
        check("R8", "busy stays low", {31'd0, busy}, 32'd0);
        check("R8", "dz_flag set", {31'd0, dz_flag}, 32'd1);
        check_hilo("R8", 32'd0, 32'd12);
        issue(3'd1, 32'd2, 32'd3);
        wait_idle(cyc);
        check("R8", "dz_flag cleared", {31'd0, dz_flag}, 32'd0);
        check_hilo("R1", 32'd0, 32'd6);

        // R9 direct loads while idle, no-op code
        issue(3'd5, 32'hAAAA5555, 32'd0);
        check_hilo("R9", 32'hAAAA5555, 32'd6);
        issue(3'd6, 32'h00000F0F, 32'd0);
        check_hilo("R9", 32'hAAAA5555, 32'h00000F0F);
        issue(3'd7, 32'h11111111, 32'd0);
        check("R9", "code 7 busy", {31'd0, busy}, 32'd0);
        check_hilo("R9", 32'hAAAA5555, 32'h00000F0F);

        // R10 abort by direct write mid-operation
        issue(3'd1, 32'h1234, 32'h10);
        repeat (4) @(negedge clk);
        check("R10", "busy before abort", {31'd0, busy}, 32'd1);
        issue(3'd6, 32'h0000DEAD, 32'd0);
        check("R10", "busy after abort", {31'd0, busy}, 32'd0);
        check_hilo("R10", 32'hAAAA5555, 32'h0000DEAD);
        repeat (40) @(negedge clk);
        check_hilo("R10", 32'hAAAA5555, 32'h0000DEAD);

        // R11 reset clears after activity
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_hilo("R11", 32'd0, 32'd0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule